// File: doc/BRIEF.md
# Center-Out Rolling Readout Sequencer

This controller empties one column segment of a photon-timing pixel array. Each segment has a fixed number of pixels (16 by default). Every pixel keeps a stored timing word (10 bits by default) and can place it on a shared tri-state bus. A pulse on `frame_start` marks the moment the pixels latch their new results. The sequencer then walks through every row of the segment, one row per line-clock pulse, while the pixels are already acquiring the next frame. Because readout and acquisition overlap, the array runs without dead time.

For each line pulse the block raises exactly one row select for one cycle, so that a single pixel drives the bus. It samples the word from the bus and shifts it out on one serial pin, most significant bit first, with a valid flag high during the shift. Rows are visited starting from the row that sits next to the array centre. A segment in the lower half of the array (`CENTER_DOWN = 1`) counts its row index down from the top index to 0. A segment in the upper half (`CENTER_DOWN = 0`) counts up from 0. All selects stay low during reset and between frames, so the bus is left undriven.

The line clock arrives as a single-cycle synchronous pulse `line_tick`. The bus value seen by the block is `bus_word`.

Top module: `readout_seq`

## Requirements
- R1: During reset and whenever no frame is in progress, `row_sel` is all zero and `ser_valid` is 0.
- R2: A `frame_start` pulse seen while idle arms a frame. After that, each row begins only when a `line_tick` pulse is seen while the block waits for the next row.
- R3: Row order: with `CENTER_DOWN = 1` the n-th row read (n from 0) has index ROWS-1-n; with `CENTER_DOWN = 0` it has index n. Row index k is selected by bit k of `row_sel`.
- R4: The cycle after an accepted `line_tick`, `row_sel` is one-hot for exactly one cycle and is zero again the cycle after.
- R5: The block samples `bus_word` at the clock edge that ends the select cycle. In the WORD_W cycles that follow, `ser_out` carries bit WORD_W-1 down to bit 0 in that order, with `ser_valid` high in exactly those cycles.
- R6: `row_sel` is zero while bits are being shifted and while the block waits between rows, so a select and a shift never overlap.
- R7: A `line_tick` seen while idle, or during a select or shift, has no effect: no select is raised and the row sequence does not move.
- R8: A `frame_start` seen while a frame is in progress has no effect: the row sequence goes on from where it was.
- R9: After ROWS rows have been shifted out, the block returns to idle. The next `frame_start` begins again from the centre-side row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse: pixels have latched a new frame |
| line_tick | input | 1 | One-cycle line-clock pulse that starts the next row |
| bus_word | input | WORD_W | Value on the shared pixel bus |
| row_sel | output | ROWS | One-hot row select, all zero when no pixel may drive |
| ser_out | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | High while `ser_out` carries a word bit |

## Verification
A wrong row counter or direction shows up one cycle after a line pulse as the wrong `row_sel` bit. It also shows up eleven cycles later as a serial word that does not match the one the bench's bus model assigns to the expected row. A shift counter off by one lengthens or shortens the `ser_valid` run and makes the next row's select appear during a shift. If a stray line or frame pulse is taken while busy, an unrequested select appears before the next real line pulse. The sweep covers both directions over every row of several frames, with stray pulses injected during shifts.

// File: rtl/rdout_pkg.sv
package rdout_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_DRIVE, SQ_SHIFT} seq_state_t;
endpackage

// File: rtl/row_sequencer.sv
module row_sequencer
  import rdout_pkg::*;
#(
  parameter int ROWS        = 16,
  parameter bit CENTER_DOWN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            line_tick,
  input  logic            shift_last,
  output logic [ROWS-1:0] row_sel,
  output logic            drive_phase,
  output logic            busy
);
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(ROWS - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] step;
  logic [IDX_W-1:0] row_idx;
  logic             step_is_last;

  function automatic logic [ROWS-1:0] onehot_of(input logic [IDX_W-1:0] idx);
    logic [ROWS-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // Visiting order is picked by the segment's position in the array
  generate
    if (CENTER_DOWN) begin : g_down
      assign row_idx = LAST_STEP - step;
    end else begin : g_up
      assign row_idx = step;
    end
  endgenerate

  assign step_is_last = (step == LAST_STEP);
  assign drive_phase  = (state == SQ_DRIVE);
  assign busy         = (state != SQ_IDLE);
  assign row_sel      = drive_phase ? onehot_of(row_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (frame_start) begin
          state <= SQ_WAIT;
          step  <= '0;
        end
        SQ_WAIT:  if (line_tick) state <= SQ_DRIVE;
        SQ_DRIVE: state <= SQ_SHIFT;
        SQ_SHIFT: if (shift_last) begin
          if (step_is_last) begin
            state <= SQ_IDLE;
          end else begin
            state <= SQ_WAIT;
            step  <= step + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R1
  idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (row_sel == '0));

  // R9
  first_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT && $past(state) == SQ_IDLE) |-> (step == '0));

  // R7
  tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_SHIFT && line_tick && !shift_last) |=> (state == SQ_SHIFT));
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] bus_word,
  output logic              ser_out,
  output logic              ser_valid,
  output logic              shift_last
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  remain;

  assign ser_out    = shreg[WORD_W-1];
  assign ser_valid  = (remain != '0);
  assign shift_last = (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      remain <= '0;
    end else if (load) begin
      shreg  <= bus_word;
      remain <= CNT_W'(WORD_W);
    end else if (remain != '0) begin
      shreg  <= shreg << 1;
      remain <= remain - 1'b1;
    end
  end

  // R5
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ser_valid && ser_out == $past(bus_word[WORD_W-1])));

  // R5
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !shift_last && !load) |=> (ser_valid && ser_out == $past(shreg[WORD_W-2])));
endmodule

// File: rtl/readout_seq.sv
module readout_seq #(
  parameter int ROWS        = 16,
  parameter int WORD_W      = 10,
  parameter bit CENTER_DOWN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_tick,
  input  logic [WORD_W-1:0] bus_word,
  output logic [ROWS-1:0]   row_sel,
  output logic              ser_out,
  output logic              ser_valid
);
  logic drive_phase;
  logic shift_last;
  logic busy;

  row_sequencer #(.ROWS(ROWS), .CENTER_DOWN(CENTER_DOWN)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_tick   (line_tick),
    .shift_last  (shift_last),
    .row_sel     (row_sel),
    .drive_phase (drive_phase),
    .busy        (busy)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (drive_phase),
    .bus_word   (bus_word),
    .ser_out    (ser_out),
    .ser_valid  (ser_valid),
    .shift_last (shift_last)
  );

  // R6
  sel_shift_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel != '0) |-> !ser_valid);

  // R4
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  // R4
  select_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel != '0) |=> (row_sel == '0));

  // R5
  shift_follows_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> ($past(row_sel) != '0));
endmodule

// File: tb/tb_readout_seq.sv
`timescale 1ns/1ps
module tb_readout_seq;
  localparam int ROWS   = 16;
  localparam int WORD_W = 10;

  logic clk = 1'b0;
  logic rst_n, frame_start, line_tick;
  logic [WORD_W-1:0] bus_lo, bus_up;
  logic [ROWS-1:0]   sel_lo, sel_up;
  logic ser_lo, ser_up, val_lo, val_up;
  int   frame_no = 0;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #2.5 clk = ~clk;

  readout_seq #(.ROWS(ROWS), .WORD_W(WORD_W), .CENTER_DOWN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_tick(line_tick),
    .bus_word(bus_lo), .row_sel(sel_lo), .ser_out(ser_lo), .ser_valid(val_lo));

  readout_seq #(.ROWS(ROWS), .WORD_W(WORD_W), .CENTER_DOWN(1'b0)) dut_up (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_tick(line_tick),
    .bus_word(bus_up), .row_sel(sel_up), .ser_out(ser_up), .ser_valid(val_up));

  // Pixel word assigned to each row, frame and half
  function automatic logic [WORD_W-1:0] word_of(input int row, input int fr, input int half);
    int v;
    v = row * 37 + fr * 113 + half * 291 + 5;
    return v[WORD_W-1:0];
  endfunction

  function automatic int decode(input logic [ROWS-1:0] s);
    int r;
    r = -1;
    for (int i = 0; i < ROWS; i++) if (s[i]) r = i;
    return r;
  endfunction

  // Bus model: only a selected pixel drives; an undriven bus reads as zero
  always_comb begin
    bus_lo = (decode(sel_lo) >= 0) ? word_of(decode(sel_lo), frame_no, 0) : '0;
    bus_up = (decode(sel_up) >= 0) ? word_of(decode(sel_up), frame_no, 1) : '0;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_quiet(input string tag);
    check(sel_lo == '0, {tag, " row_sel lo"}, sel_lo, 0);
    check(sel_up == '0, {tag, " row_sel up"}, sel_up, 0);
    check(!val_lo && !val_up, {tag, " ser_valid"}, {val_lo, val_up}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; frame_start = 1'b0; line_tick = 1'b0;
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after reset");

    // line pulse while idle
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    check_quiet("R7 idle tick");
    @(negedge clk);
    check_quiet("R7 idle tick later");

    for (int f = 0; f < 3; f++) begin
      frame_no = f;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      @(negedge clk);
      for (int s = 0; s < ROWS; s++) begin
        int rlo, rup;
        logic [WORD_W-1:0] wlo, wup;
        rlo = ROWS - 1 - s;
        rup = s;
        wlo = word_of(rlo, f, 0);
        wup = word_of(rup, f, 1);
        check_quiet("R6 R7 R2 wait before tick");
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        check(sel_lo == (ROWS'(1) << rlo), "R3 R4 row_sel lo", sel_lo, ROWS'(1) << rlo);
        check(sel_up == (ROWS'(1) << rup), "R3 R4 row_sel up", sel_up, ROWS'(1) << rup);
        for (int k = 0; k < WORD_W; k++) begin
          if (k == 3 && (s % 2 == 1)) begin
            line_tick = 1'b1;
            frame_start = 1'b1;   // R8 stray frame pulse mid-frame
          end
          if (k == 4) begin
            line_tick = 1'b0;
            frame_start = 1'b0;
          end
          @(negedge clk);
          check(val_lo && val_up, "R5 ser_valid high", {val_lo, val_up}, 3);
          check(ser_lo == wlo[WORD_W-1-k], "R5 R8 ser_out lo", ser_lo, wlo[WORD_W-1-k]);
          check(ser_up == wup[WORD_W-1-k], "R5 R8 ser_out up", ser_up, wup[WORD_W-1-k]);
          check(sel_lo == '0 && sel_up == '0, "R6 no select in shift", {sel_lo, sel_up}, 0);
        end
        @(negedge clk);
        check(!val_lo && !val_up, "R5 ser_valid low after word", {val_lo, val_up}, 0);
      end
      check_quiet("R9 idle after frame");
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      check_quiet("R7 R9 tick after frame");
      @(negedge clk);
      check_quiet("R1 between frames");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule